// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupt

This block sits between the digital output of an on-chip analog comparator and the rest of the chip. It brings four raw comparator results into the clock domain through a two-stage synchronizer and picks one of them with a source-select code. It can optionally invert the picked result and can force it inactive for a fixed blanking window that starts when a slope operation completes. The conditioned value is presented as a status bit. An interrupt pulse is raised on a rising, falling or either edge of that conditioned value.

Software configures the block through a single 16-bit control word, written with a write strobe and read back combinationally. The read-back word also carries the live status bit. A change to the edge mode, polarity or source select would otherwise look like a comparator edge. The block masks the interrupt for the one cycle in which such a change takes effect. A parameter can turn this masking off and let such edges through.

Top module: `cmp_condition`

## Requirements
- R1: After reset the control word reads back as all zeros, `cmp_status` is 0 and `cmp_irq` is 0.
- R2: Source-select field `cfg_wdata[6:4]` codes 0 to 3 pick `cmp_in[code]`. Codes 4 to 7 are reserved and pick a constant 0.
- R3: With the invert bit `cfg_wdata[3]` set to 1, the selected value is inverted before the status and edge stages. With it at 0, the value passes unchanged.
- R4: A change on `cmp_in` reaches `cmp_status` after two rising clock edges. `cfg_rdata[15]` always equals `cmp_status`, and writes to bit 15 are ignored.
- R5: The edge-mode field `cfg_wdata[2:1]` selects the trigger: 00 none, 01 rising, 10 falling, 11 either. The edge is taken on the conditioned status, after inversion. `cmp_irq` is high for one cycle, on the cycle after the edge following the status change.
- R6: While the enable bit `cfg_wdata[0]` is 0, `cmp_irq` stays 0.
- R7: When enabled, a `slope_done` pulse starts a blanking window of BLANK_LEN cycles. If the blank-enable bit `cfg_wdata[7]` is 1, `cmp_status` is forced to 0 during the window. If that bit is 0, the window has no effect.
- R8: When the enable bit is 0, any pending blanking window is cleared and `slope_done` starts none.
- R9: A write that changes the edge mode, invert bit or source select raises no interrupt in the cycle after it takes effect, even when the conditioned value flips.
- R10: Filter-enable bit `cfg_wdata[8]` is stored and read back at `cfg_rdata[8]`. It has no effect on status or interrupts. Other unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back including live status at bit 15 |
| cmp_in | input | NUM_SRC | Raw comparator outputs, asynchronous |
| slope_done | input | 1 | One-cycle pulse marking the end of a slope operation |
| cmp_status | output | 1 | Conditioned comparator status |
| cmp_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `slope_done` and `cfg_we` are synchronous to `clk`. They also assume that `cmp_in` may change at any cycle, because the synchronizer absorbs it. The edge check assumes that the status seen one and two cycles back is the same history the edge detector keeps. This holds because the history register is loaded with the conditioned value every cycle. The stimulus drives every input just after the falling edge. It keeps the enable bit mostly set so that blanking windows and edges actually occur, and it writes arbitrary control words, reserved select codes included, at random points.

// File: rtl/cmpc_pkg.sv
// Package: shared types and control-word field positions for the comparator
// conditioner. Assumes a 16-bit control word with the layout below.
package cmpc_pkg;

    localparam int CFG_W    = 16;
    localparam int SEL_W    = 3;
    localparam int POS_EN   = 0;
    localparam int POS_MODE = 1;   // two bits
    localparam int POS_INV  = 3;
    localparam int POS_SEL  = 4;   // SEL_W bits
    localparam int POS_BLK  = 7;
    localparam int POS_FILT = 8;
    localparam int POS_STAT = 15;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic             filt_en;
        logic             blank_en;
        logic [SEL_W-1:0] sel;
        logic             inv;
        edge_mode_e       mode;
        logic             en;
    } cfg_t;

    // Decode a written control word into its fields.
    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.en       = w[POS_EN];
        c.mode     = edge_mode_e'(w[POS_MODE +: 2]);
        c.inv      = w[POS_INV];
        c.sel      = w[POS_SEL +: SEL_W];
        c.blank_en = w[POS_BLK];
        c.filt_en  = w[POS_FILT];
        return c;
    endfunction

endpackage

// File: rtl/cmpc_regs.sv
// Module: control word storage and read-back.
// Holds the configuration, flags writes that alter mode, polarity or source
// select, and builds the read-back word with the live status in bit 15.
// Assumes cfg_we is synchronous to clk.
module cmpc_regs
    import cmpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             status,
    output cfg_t             cfg,
    output logic             chg,
    output logic [CFG_W-1:0] rdata
);

    cfg_t nxt;

    // Decode incoming write data.
    always_comb nxt = unpack_cfg(wdata);

    // Store configuration and flag edge-relevant changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            chg <= 1'b0;
        end else begin
            chg <= we && ((nxt.mode != cfg.mode) || (nxt.inv != cfg.inv) ||
                          (nxt.sel != cfg.sel));
            if (we) cfg <= nxt;
        end
    end

    // Assemble the read-back word.
    always_comb begin
        rdata                    = '0;
        rdata[POS_EN]            = cfg.en;
        rdata[POS_MODE +: 2]     = cfg.mode;
        rdata[POS_INV]           = cfg.inv;
        rdata[POS_SEL +: SEL_W]  = cfg.sel;
        rdata[POS_BLK]           = cfg.blank_en;
        rdata[POS_FILT]          = cfg.filt_en;
        rdata[POS_STAT]          = status;
    end

endmodule

// File: rtl/cmpc_front.sv
// Module: comparator front end.
// Synchronizes all raw comparator inputs, picks one by select code (reserved
// codes give 0), applies optional inversion and gates the result off during
// the post-slope blanking window. Assumes cmp_raw is asynchronous and
// slope_done is a synchronous pulse.
module cmpc_front
    import cmpc_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_LEN   = 8,
    localparam int CNT_W      = $clog2(BLANK_LEN + 1)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cmp_raw,
    input  logic               slope_done,
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    input  logic               inv,
    input  logic               blank_en,
    output logic               blank_act,
    output logic               cond
);

    logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
    logic [CNT_W-1:0]   blank_cnt;
    logic               picked;

    // Synchronizer chain, one register stage per generate step.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= cmp_raw;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Pick the selected source; reserved codes leave it at 0.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) picked = sync_q[SYNC_STAGES-1][i];
        end
    end

    // Blanking window counter, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                blank_cnt <= '0;
        else if (!en)              blank_cnt <= '0;
        else if (slope_done)       blank_cnt <= CNT_W'(BLANK_LEN);
        else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;
    end

    assign blank_act = (blank_cnt != '0);

    // Polarity then blanking.
    always_comb cond = (picked ^ inv) & ~(blank_en & blank_act);

endmodule

// File: rtl/cmpc_edge.sv
// Module: edge detector and interrupt pulse.
// Compares the conditioned value with its value one cycle earlier and raises
// a one-cycle interrupt for the selected edge kind. SUPPRESS_CFG selects
// whether the cycle after a configuration change is masked.
module cmpc_edge
    import cmpc_pkg::*;
#(
    parameter bit SUPPRESS_CFG = 1'b1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond,
    input  logic       en,
    input  edge_mode_e mode,
    input  logic       chg,
    output logic       irq
);

    logic prev_q;
    logic hit;
    logic mask;

    // Decode the edge kind against the history value.
    always_comb begin
        unique case (mode)
            EDGE_RISE: hit = cond & ~prev_q;
            EDGE_FALL: hit = ~cond & prev_q;
            EDGE_BOTH: hit = cond ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // Variant pick: mask config-induced edges or let them pass.
    if (SUPPRESS_CFG) begin : g_mask
        assign mask = chg;
    end else begin : g_pass
        logic unused_chg;
        assign unused_chg = chg;
        assign mask = 1'b0;
    end

    // Reload history every cycle and register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            prev_q <= cond;
            irq    <= en & ~mask & hit;
        end
    end

endmodule

// File: rtl/cmp_condition.sv
// Module: comparator output conditioner, top level.
// Joins control storage, front end and edge detector. Assumes all inputs but
// cmp_in are synchronous to clk; reset is synchronous and active low.
module cmp_condition
    import cmpc_pkg::*;
#(
    parameter int NUM_SRC      = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_LEN    = 8,
    parameter bit SUPPRESS_CFG = 1'b1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [NUM_SRC-1:0] cmp_in,
    input  logic               slope_done,
    output logic               cmp_status,
    output logic               cmp_irq
);

    cfg_t cfg_q;
    logic cfg_chg;
    logic blank_act;
    logic cond;

    cmpc_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .status (cond),
        .cfg    (cfg_q),
        .chg    (cfg_chg),
        .rdata  (cfg_rdata)
    );

    cmpc_front #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES),
        .BLANK_LEN   (BLANK_LEN)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw    (cmp_in),
        .slope_done (slope_done),
        .en         (cfg_q.en),
        .sel        (cfg_q.sel),
        .inv        (cfg_q.inv),
        .blank_en   (cfg_q.blank_en),
        .blank_act  (blank_act),
        .cond       (cond)
    );

    cmpc_edge #(
        .SUPPRESS_CFG (SUPPRESS_CFG)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond),
        .en    (cfg_q.en),
        .mode  (cfg_q.mode),
        .chg   (cfg_chg),
        .irq   (cmp_irq)
    );

    assign cmp_status = cond;

endmodule

// File: rtl/cmp_condition_chk.sv
// Module: assertion checker for cmp_condition, bound below.
// Assumes the default SUPPRESS_CFG variant for the change-masking property.
module cmp_condition_chk #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 3
)(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       mode,
    input logic             inv,
    input logic [SEL_W-1:0] sel,
    input logic             blank_en,
    input logic             blank_act,
    input logic             chg,
    input logic             status,
    input logic             irq
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(sel) >= NUM_SRC) && !inv) |-> !status);              // R2

    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(status) != $past(status, 2)));              // R5

    AST_IRQ_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(mode) != 2'b00));                           // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));                                        // R6

    AST_BLANK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_en && blank_act) |-> !status);                      // R7

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !blank_act);                                       // R8

    AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !irq);                                             // R9

endmodule

bind cmp_condition cmp_condition_chk #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (cmpc_pkg::SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_q.en),
    .mode      (cfg_q.mode),
    .inv       (cfg_q.inv),
    .sel       (cfg_q.sel),
    .blank_en  (cfg_q.blank_en),
    .blank_act (blank_act),
    .chg       (cfg_chg),
    .status    (cmp_status),
    .irq       (cmp_irq)
);

// File: tb/sim_cmp_condition.sv
module sim_cmp_condition;

    localparam int BL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  cmp_in = '0;
    logic        slope_done = 1'b0;
    logic        cmp_status;
    logic        cmp_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cmp_condition u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cmp_in     (cmp_in),
        .slope_done (slope_done),
        .cmp_status (cmp_status),
        .cmp_irq    (cmp_irq)
    );

    // Reference model built from the requirements
    logic [3:0] m_s1, m_s2;
    logic       m_en, m_inv, m_blk, m_filt, m_chg, m_prev, m_irq;
    logic [1:0] m_mode;
    logic [2:0] m_sel;
    int         m_cnt;

    function automatic logic f_cond(logic [3:0] s, logic [2:0] sel, logic inv,
                                    logic blk, logic act);
        logic b;
        b = (sel < 3'd4) ? s[sel[1:0]] : 1'b0;          // R2
        return (b ^ inv) & ~(blk & act);                 // R3, R7
    endfunction

    function automatic logic f_hit(logic [1:0] mode, logic cur, logic prev);
        case (mode)
            2'b01:   return cur & ~prev;
            2'b10:   return ~cur & prev;
            2'b11:   return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] mk(logic en, logic [1:0] mode, logic inv,
                                       logic [2:0] sel, logic blk, logic filt);
        return {7'b0, filt, blk, sel, inv, mode, en};
    endfunction

    logic m_cur;
    always_comb m_cur = f_cond(m_s2, m_sel, m_inv, m_blk, m_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_en <= 0; m_inv <= 0; m_blk <= 0;
            m_filt <= 0; m_chg <= 0; m_prev <= 0; m_irq <= 0; m_mode <= 0;
            m_sel <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= cmp_in;
            m_s2 <= m_s1;
            m_chg <= cfg_we && ((cfg_wdata[2:1] != m_mode) ||
                     (cfg_wdata[3] != m_inv) || (cfg_wdata[6:4] != m_sel));
            if (cfg_we) begin
                m_en <= cfg_wdata[0]; m_mode <= cfg_wdata[2:1];
                m_inv <= cfg_wdata[3]; m_sel <= cfg_wdata[6:4];
                m_blk <= cfg_wdata[7]; m_filt <= cfg_wdata[8];
            end
            if (!m_en)           m_cnt <= 0;
            else if (slope_done) m_cnt <= BL;
            else if (m_cnt > 0)  m_cnt <= m_cnt - 1;
            m_irq  <= m_en && !m_chg && f_hit(m_mode, m_cur, m_prev);
            m_prev <= m_cur;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4", {15'b0, cmp_status}, {15'b0, m_cur});
            chk("R5", {15'b0, cmp_irq}, {15'b0, m_irq});
            chk("R10", cfg_rdata, {m_cur, 6'b0, m_filt, m_blk, m_sel, m_inv, m_mode, m_en});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int irq_seen;
        void'($urandom(32'd2718));
        step(3);
        chk("R1", cfg_rdata, 16'h0000);
        chk("R1", {15'b0, cmp_status}, 16'h0);
        chk("R1", {15'b0, cmp_irq}, 16'h0);
        rst_n = 1'b1;
        step(1);

        // R2 reserved and valid select codes
        wr(mk(1, 2'b00, 0, 3'd5, 0, 0)); cmp_in = 4'hF; step(3);
        chk("R2", {15'b0, cmp_status}, 16'h0);
        wr(mk(1, 2'b00, 0, 3'd2, 0, 0)); cmp_in = 4'b0100; step(3);
        chk("R2", {15'b0, cmp_status}, 16'h1);
        cmp_in = 4'b1011; step(3);
        chk("R2", {15'b0, cmp_status}, 16'h0);

        // R3 inversion
        wr(mk(1, 2'b00, 1, 3'd2, 0, 0)); step(3);
        chk("R3", {15'b0, cmp_status}, 16'h1);

        // R4 two-edge latency and read-only status bit
        wr(mk(1, 2'b00, 0, 3'd0, 0, 0)); cmp_in = 4'h0; step(3);
        cmp_in = 4'h1;
        step(1); chk("R4", {15'b0, cmp_status}, 16'h0);
        step(1); chk("R4", {15'b0, cmp_status}, 16'h1);
        chk("R4", {15'b0, cfg_rdata[15]}, 16'h1);
        cmp_in = 4'h0; step(3);
        wr(mk(1, 2'b00, 0, 3'd0, 0, 0) | 16'h8000); step(1);
        chk("R4", {15'b0, cfg_rdata[15]}, 16'h0);

        // R5 rising edge pulse timing
        wr(mk(1, 2'b01, 0, 3'd0, 0, 0)); step(4);
        cmp_in = 4'h1;
        step(2); chk("R5", {15'b0, cmp_irq}, 16'h0);
        step(1); chk("R5", {15'b0, cmp_irq}, 16'h1);
        step(1); chk("R5", {15'b0, cmp_irq}, 16'h0);
        // R5 falling mode sees the inverted signal
        cmp_in = 4'h0; step(4);
        wr(mk(1, 2'b10, 1, 3'd0, 0, 0)); step(4);
        cmp_in = 4'h1; step(3);
        chk("R5", {15'b0, cmp_irq}, 16'h1);

        // R6 disabled block stays quiet
        wr(mk(0, 2'b11, 0, 3'd0, 0, 0));
        irq_seen = 0;
        for (int i = 0; i < 12; i++) begin
            cmp_in = {3'b0, i[1]};
            step(1);
            if (cmp_irq) irq_seen++;
        end
        chk("R6", 16'(irq_seen), 16'h0);

        // R7 blanking window length
        cmp_in = 4'h1;
        wr(mk(1, 2'b01, 0, 3'd0, 1, 0)); step(4);
        chk("R7", {15'b0, cmp_status}, 16'h1);
        slope_done = 1'b1; step(1); slope_done = 1'b0;
        chk("R7", {15'b0, cmp_status}, 16'h0);
        step(BL - 1); chk("R7", {15'b0, cmp_status}, 16'h0);
        step(1);      chk("R7", {15'b0, cmp_status}, 16'h1);
        wr(mk(1, 2'b01, 0, 3'd0, 0, 0));
        slope_done = 1'b1; step(1); slope_done = 1'b0;
        chk("R7", {15'b0, cmp_status}, 16'h1);

        // R8 disabling clears a pending window
        wr(mk(1, 2'b01, 0, 3'd0, 1, 0)); step(BL + 2);
        slope_done = 1'b1; step(1); slope_done = 1'b0;
        wr(mk(0, 2'b01, 0, 3'd0, 1, 0)); step(1);
        chk("R8", {15'b0, cmp_status}, 16'h1);
        slope_done = 1'b1; step(1); slope_done = 1'b0;
        chk("R8", {15'b0, cmp_status}, 16'h1);

        // R9 polarity and select changes do not raise interrupts
        wr(mk(1, 2'b11, 0, 3'd0, 0, 0)); step(4);
        irq_seen = 0;
        wr(mk(1, 2'b11, 1, 3'd0, 0, 0));
        for (int i = 0; i < 4; i++) begin step(1); if (cmp_irq) irq_seen++; end
        cmp_in = 4'b0001;
        step(4);
        wr(mk(1, 2'b11, 1, 3'd1, 0, 0));
        for (int i = 0; i < 4; i++) begin step(1); if (cmp_irq) irq_seen++; end
        chk("R9", 16'(irq_seen), 16'h0);

        // R10 filter bit is stored only
        wr(mk(1, 2'b11, 1, 3'd1, 0, 1)); step(2);
        chk("R10", {15'b0, cfg_rdata[8]}, 16'h1);
        chk("R10", {15'b0, cmp_status}, 16'h1);

        // Constrained random phase
        for (int c = 0; c < 4000; c++) begin
            if (($urandom % 3) == 0) cmp_in = 4'($urandom);
            slope_done = (($urandom % 20) == 0);
            if (($urandom % 15) == 0) begin
                logic [15:0] d;
                d = 16'($urandom);
                if (($urandom % 5) != 0) d[0] = 1'b1;
                cfg_we = 1'b1; cfg_wdata = d;
            end else begin
                cfg_we = 1'b0;
            end
            step(1);
        end
        cfg_we = 1'b0; slope_done = 1'b0;
        step(2);
        finish_run();
    end

endmodule